// File: doc/BRIEF.md
# Egress Translation Window Matcher

This block sits on the outbound side of a memory-mapped bridge. It checks each outgoing read or write address against a bank of programmable translation windows. Each window has a source base, a destination base and a control word. The control word holds an enable, a power-of-two size code and attribute override settings. When a window claims the address, the block replaces the upper address bits with the destination base and produces the three ordering/coherency attribute bits {ID-based ordering, relaxed ordering, no snoop} that go with the transaction.

A 32-bit register port programs the windows, and reads of it are combinational. The request side takes one address per cycle and returns the hit flag, the translated address and the attributes one clock later. A three-bit global permission input clears any attribute that the link configuration does not currently allow. When no window claims the address, the address passes through unchanged.

Top module: `egress_xlat_matcher`

## Requirements
- R1: After reset every register reads zero, no window is enabled, and rsp_valid and rsp_hit are 0.
- R2: The control word (register offset 0x08) holds the enable in bit 0, the size code in bits 20:16, the override enable in bit 23, the read attribute field in bits 27:24 and the write attribute field in bits 31:28. Every other bit reads 0 and ignores writes.
- R3: A size code written above SIZE_MAX is stored, and reads back, as SIZE_MAX.
- R4: Window i occupies register addresses i*0x20 to i*0x20+0x1F. Source base low/high words sit at offsets 0x00/0x04 and destination base low/high words at 0x10/0x14. Base bits 11:0 read 0. Other offsets read 0 and ignore writes.
- R5: A window with size code s hits only when it is enabled and address bits [63:12+s] equal its source base bits [63:12+s], so it spans 2^(12+s) bytes.
- R6: On a hit, the translated address is destination base bits [63:12+s] followed by request address bits [11+s:0].
- R7: When several windows hit, the lowest-numbered one supplies the result.
- R8: On a miss, rsp_hit is 0, rsp_addr equals the request address and rsp_attr is 0.
- R9: With override enabled, a hitting write takes {IDO,RO,NS} = write field bits [2:0] (bit 2 = IDO, bit 0 = NS) and a hitting read takes read field bits [2:0]. Field bit 3 is unused.
- R10: With override disabled, a hitting read or write gets attributes 000.
- R11: Each attribute bit is cleared when the matching attr_permit bit is 0 (bit 2 IDO, bit 1 RO, bit 0 NS).
- R12: rsp_valid is req_valid delayed by one clock, and the result belongs to the request from the previous cycle. Register writes take effect from the following cycle. In a cycle after req_valid was 0, rsp_hit is 0 and rsp_attr is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Register byte address: window index above bit 5, offset in bits 4:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| attr_permit | input | 3 | Global attribute permissions {IDO,RO,NS} |
| req_valid | input | 1 | Request address valid |
| req_is_write | input | 1 | 1 = write transaction, 0 = read |
| req_addr | input | 64 | Outgoing address |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_attr | output | 3 | Resulting attributes {IDO,RO,NS} |

## Verification
The assertions take for granted that the window hit vector is a pure function of the request and the stored registers. They also assume attr_permit holds steady for the cycle in which a request is sampled, and that SIZE_MAX is small enough for 12+SIZE_MAX to stay below 64. The stimulus changes every input only on the falling edge. It programs windows through the register port alone, keeps overlapping windows on a common base so the priority order is what decides the result, and sweeps size codes only up to the configured limit, apart from the one deliberate overflow write that tests clamping.

// File: rtl/egx_pkg.sv
package egx_pkg;
  localparam int ADDR_W       = 64;
  localparam int GRANULE_BITS = 12;
  localparam int BASE_W       = ADDR_W - GRANULE_BITS;

  // register offsets inside one window's 32-byte slot
  localparam logic [4:0] OFF_SRC_LO = 5'h00;
  localparam logic [4:0] OFF_SRC_HI = 5'h04;
  localparam logic [4:0] OFF_CTRL   = 5'h08;
  localparam logic [4:0] OFF_DST_LO = 5'h10;
  localparam logic [4:0] OFF_DST_HI = 5'h14;

  typedef logic [2:0] attr_t; // {IDO, RO, NS}

  typedef struct packed {
    logic [3:0] wattr;
    logic [3:0] rattr;
    logic       ovr;
    logic [4:0] size;
    logic       en;
  } win_ctrl_t;

  function automatic logic [4:0] clamp_size(input logic [4:0] req, input logic [4:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  function automatic win_ctrl_t unpack_ctrl(input logic [31:0] w, input logic [4:0] lim);
    win_ctrl_t c;
    c.en    = w[0];
    c.size  = clamp_size(w[20:16], lim);
    c.ovr   = w[23];
    c.rattr = w[27:24];
    c.wattr = w[31:28];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctrl(input win_ctrl_t c);
    logic [31:0] r;
    r        = '0;
    r[0]     = c.en;
    r[20:16] = c.size;
    r[23]    = c.ovr;
    r[27:24] = c.rattr;
    r[31:28] = c.wattr;
    return r;
  endfunction

  // ones below bit 12+size
  function automatic logic [ADDR_W-1:0] span_mask(input logic [4:0] size);
    logic [6:0] sh;
    sh = 7'(GRANULE_BITS) + {2'b00, size};
    return (ADDR_W'(1) << sh) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] base_full(input logic [BASE_W-1:0] b);
    return {b, {GRANULE_BITS{1'b0}}};
  endfunction

  function automatic logic window_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [BASE_W-1:0] src,
                                      input win_ctrl_t c);
    return c.en && (((addr ^ base_full(src)) & ~span_mask(c.size)) == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] xlate(input logic [ADDR_W-1:0] addr,
                                              input logic [BASE_W-1:0] dst,
                                              input logic [4:0] size);
    logic [ADDR_W-1:0] m;
    m = span_mask(size);
    return (base_full(dst) & ~m) | (addr & m);
  endfunction

  function automatic attr_t select_attr(input win_ctrl_t c, input logic is_wr, input attr_t permit);
    attr_t a;
    if (!c.ovr) a = '0;
    else        a = is_wr ? c.wattr[2:0] : c.rattr[2:0];
    return a & permit;
  endfunction
endpackage

// File: rtl/egx_win_regs.sv
module egx_win_regs import egx_pkg::*; #(
  parameter int NUM_WIN  = 8,
  parameter int SIZE_MAX = 20,
  localparam int WIN_AW  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW  = WIN_AW + 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [REG_AW-1:0]               reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic [NUM_WIN-1:0][BASE_W-1:0]  src_base,
  output logic [NUM_WIN-1:0][BASE_W-1:0]  dst_base,
  output win_ctrl_t [NUM_WIN-1:0]         win_ctrl
);
  localparam logic [4:0] SIZE_LIM = 5'(SIZE_MAX);
  localparam int LO_W = 32 - GRANULE_BITS;

  logic [WIN_AW-1:0] win_idx;
  logic [4:0]        win_off;
  assign win_idx = reg_addr[REG_AW-1:5];
  assign win_off = reg_addr[4:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              sel;
    logic [BASE_W-1:0] src_q;
    logic [BASE_W-1:0] dst_q;
    win_ctrl_t         ctrl_q;

    assign sel = reg_we && (win_idx == WIN_AW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= '0;
        dst_q  <= '0;
        ctrl_q <= '0;
      end else if (sel) begin
        case (win_off)
          OFF_SRC_LO: src_q[LO_W-1:0]      <= reg_wdata[31:GRANULE_BITS];
          OFF_SRC_HI: src_q[BASE_W-1:LO_W] <= reg_wdata;
          OFF_CTRL:   ctrl_q               <= unpack_ctrl(reg_wdata, SIZE_LIM);
          OFF_DST_LO: dst_q[LO_W-1:0]      <= reg_wdata[31:GRANULE_BITS];
          OFF_DST_HI: dst_q[BASE_W-1:LO_W] <= reg_wdata;
          default: ;
        endcase
      end
    end

    assign src_base[w] = src_q;
    assign dst_base[w] = dst_q;
    assign win_ctrl[w] = ctrl_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(win_idx) < NUM_WIN) begin
      case (win_off)
        OFF_SRC_LO: reg_rdata = {src_base[win_idx][LO_W-1:0], {GRANULE_BITS{1'b0}}};
        OFF_SRC_HI: reg_rdata = src_base[win_idx][BASE_W-1:LO_W];
        OFF_CTRL:   reg_rdata = pack_ctrl(win_ctrl[win_idx]);
        OFF_DST_LO: reg_rdata = {dst_base[win_idx][LO_W-1:0], {GRANULE_BITS{1'b0}}};
        OFF_DST_HI: reg_rdata = dst_base[win_idx][BASE_W-1:LO_W];
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/egx_win_match.sv
module egx_win_match import egx_pkg::*; #(
  parameter int NUM_WIN = 8
) (
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic                            req_is_write,
  input  attr_t                           attr_permit,
  input  logic [NUM_WIN-1:0][BASE_W-1:0]  src_base,
  input  logic [NUM_WIN-1:0][BASE_W-1:0]  dst_base,
  input  win_ctrl_t [NUM_WIN-1:0]         win_ctrl,
  output logic [NUM_WIN-1:0]              win_hit,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_xaddr,
  output attr_t [NUM_WIN-1:0]             win_attr
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign win_hit[w]   = window_hit(req_addr, src_base[w], win_ctrl[w]);
    assign win_xaddr[w] = xlate(req_addr, dst_base[w], win_ctrl[w].size);
    assign win_attr[w]  = select_attr(win_ctrl[w], req_is_write, attr_permit);
  end
endmodule

// File: rtl/egx_prio_pick.sv
module egx_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam logic [N-1:0] BELOW = (N'(1) << i) - N'(1);
    assign grant[i] = req[i] && ((req & BELOW) == '0);
  end
  assign any = |req;
endmodule

// File: rtl/egress_xlat_matcher.sv
module egress_xlat_matcher import egx_pkg::*; #(
  parameter int NUM_WIN  = 8,
  parameter int SIZE_MAX = 20,
  localparam int WIN_AW  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW  = WIN_AW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [2:0]        attr_permit,
  input  logic              req_valid,
  input  logic              req_is_write,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [63:0]       rsp_addr,
  output logic [2:0]        rsp_attr
);
  logic [NUM_WIN-1:0][BASE_W-1:0] src_base;
  logic [NUM_WIN-1:0][BASE_W-1:0] dst_base;
  win_ctrl_t [NUM_WIN-1:0]        win_ctrl;
  logic [NUM_WIN-1:0]             win_hit;
  logic [NUM_WIN-1:0]             win_pick;
  logic                           any_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_xaddr;
  attr_t [NUM_WIN-1:0]            win_attr;
  logic [NUM_WIN-1:0][4:0]        win_size;
  logic [ADDR_W-1:0]              sel_addr;
  attr_t                          sel_attr;

  egx_win_regs #(.NUM_WIN(NUM_WIN), .SIZE_MAX(SIZE_MAX)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .win_ctrl  (win_ctrl)
  );

  egx_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .req_addr     (req_addr),
    .req_is_write (req_is_write),
    .attr_permit  (attr_permit),
    .src_base     (src_base),
    .dst_base     (dst_base),
    .win_ctrl     (win_ctrl),
    .win_hit      (win_hit),
    .win_xaddr    (win_xaddr),
    .win_attr     (win_attr)
  );

  egx_prio_pick #(.N(NUM_WIN)) u_pick (
    .req   (win_hit),
    .grant (win_pick),
    .any   (any_hit)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_size
    assign win_size[w] = win_ctrl[w].size;
  end

  // one-hot AND-OR select; a miss falls back to the raw address
  always_comb begin
    sel_addr = '0;
    sel_attr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      sel_addr = sel_addr | ({ADDR_W{win_pick[w]}} & win_xaddr[w]);
      sel_attr = sel_attr | ({3{win_pick[w]}} & win_attr[w]);
    end
    if (!any_hit) sel_addr = req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_attr  <= req_valid ? sel_attr : 3'b000;
      if (req_valid) rsp_addr <= sel_addr;
    end
  end
endmodule

// File: rtl/egx_matcher_chk.sv
module egx_matcher_chk import egx_pkg::*; #(
  parameter int NUM_WIN  = 8,
  parameter int SIZE_MAX = 20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [63:0]              req_addr,
  input logic [2:0]               attr_permit,
  input logic                     rsp_valid,
  input logic                     rsp_hit,
  input logic [63:0]              rsp_addr,
  input logic [2:0]               rsp_attr,
  input logic [NUM_WIN-1:0]       win_hit,
  input logic [NUM_WIN-1:0]       win_pick,
  input logic [NUM_WIN-1:0][4:0]  win_size
);
  // R12: result valid exactly one cycle after a request
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && rsp_attr == 3'b000));

  // R7: at most one winner, never with a lower-numbered window also hitting
  a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_pick));
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_hit & (win_pick - 1'b1)) == '0) && ((|win_hit) == (|win_pick)));

  // R8: a miss passes the address through with no attributes
  a_r8_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit == '0) |=>
      (!rsp_hit && rsp_addr == $past(req_addr) && rsp_attr == 3'b000));

  // R11: no attribute leaves that the permission input forbade
  a_r11_permit_mask: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_attr & ~$past(attr_permit)) == 3'b000));

  // R5: a reported hit always belongs to a valid result
  a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R3: stored size never exceeds the limit
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_sz
    a_r3_size_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      win_size[g] <= 5'(SIZE_MAX));
  end
endmodule

bind egress_xlat_matcher egx_matcher_chk #(.NUM_WIN(NUM_WIN), .SIZE_MAX(SIZE_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .attr_permit (attr_permit),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_addr    (rsp_addr),
  .rsp_attr    (rsp_attr),
  .win_hit     (win_hit),
  .win_pick    (win_pick),
  .win_size    (win_size)
);

// File: tb/sim_egress_xlat_matcher.sv
module sim_egress_xlat_matcher;
  localparam int NW   = 8;
  localparam int SMAX = 20;
  localparam int RAW  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  attr_permit = 3'b111;
  logic        req_valid = 1'b0;
  logic        req_is_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_attr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench shadow of programmed state
  logic [63:0] m_src [NW];
  logic [63:0] m_dst [NW];
  bit          m_en  [NW];
  int          m_size[NW];
  bit          m_ovr [NW];
  logic [3:0]  m_ra  [NW];
  logic [3:0]  m_wa  [NW];

  egress_xlat_matcher #(.NUM_WIN(NW), .SIZE_MAX(SMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .attr_permit(attr_permit),
    .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_attr(rsp_attr)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RAW'(addr); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    @(negedge clk);
    reg_addr = RAW'(addr);
    #1 d = reg_rdata;
  endtask

  task automatic set_win(input int w, input logic [63:0] src, input logic [63:0] dst,
                         input bit en, input int size, input bit ovr,
                         input logic [3:0] ra, input logic [3:0] wa);
    logic [31:0] c;
    c = {wa, ra, ovr, 2'b00, 5'(size), 15'd0, en};
    wr(w*32 + 'h00, src[31:0]);
    wr(w*32 + 'h04, src[63:32]);
    wr(w*32 + 'h10, dst[31:0]);
    wr(w*32 + 'h14, dst[63:32]);
    wr(w*32 + 'h08, c);
    m_src[w] = {src[63:12], 12'd0};
    m_dst[w] = {dst[63:12], 12'd0};
    m_en[w] = en; m_size[w] = (size > SMAX) ? SMAX : size;
    m_ovr[w] = ovr; m_ra[w] = ra; m_wa[w] = wa;
  endtask

  task automatic clear_all();
    for (int w = 0; w < NW; w++) begin
      wr(w*32 + 'h08, 32'd0);
      m_en[w] = 1'b0;
    end
  endtask

  // arithmetic model: shift-based compare, lowest index first
  task automatic model(input logic [63:0] a, input bit isw, input logic [2:0] perm,
                       output bit h, output logic [63:0] xa, output logic [2:0] at);
    h = 1'b0; xa = a; at = 3'b000;
    for (int w = 0; w < NW; w++) begin
      int k;
      k = 12 + m_size[w];
      if (!h && m_en[w] && ((a >> k) == (m_src[w] >> k))) begin
        h  = 1'b1;
        xa = ((m_dst[w] >> k) << k) | (a - ((a >> k) << k));
        if (m_ovr[w]) at = (isw ? m_wa[w][2:0] : m_ra[w][2:0]) & perm;
      end
    end
  endtask

  task automatic do_req(input logic [63:0] a, input bit isw, input logic [2:0] perm);
    bit eh; logic [63:0] ea; logic [2:0] et;
    model(a, isw, perm, eh, ea, et);
    @(negedge clk);
    req_valid = 1'b1; req_is_write = isw; req_addr = a; attr_permit = perm;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 valid", 64'(rsp_valid), 64'd1);
    chk(eh ? "R5 hit" : "R5/R8 miss", 64'(rsp_hit), 64'(eh));
    chk(eh ? "R6 xaddr" : "R8 passthru", rsp_addr, ea);
    chk(eh ? "R9/R10/R11 attr" : "R8 attr", 64'(rsp_attr), 64'(et));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R12 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int w = 0; w < NW; w++) begin
      m_src[w] = '0; m_dst[w] = '0; m_en[w] = 0; m_size[w] = 0;
      m_ovr[w] = 0; m_ra[w] = '0; m_wa[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_hit", 64'(rsp_hit), 64'd0);
    for (int w = 0; w < NW; w++) begin
      rd(w*32 + 'h08, d); chk("R1 ctrl", 64'(d), 64'd0);
      rd(w*32 + 'h00, d); chk("R1 src_lo", 64'(d), 64'd0);
    end
    do_req(64'h0000_0000_0000_0000, 1'b0, 3'b111);

    // R2/R3: control field layout and size clamp
    wr(3*32 + 'h08, 32'hFFFF_FFFF);
    rd(3*32 + 'h08, d);
    chk("R2/R3 ctrl all-ones", 64'(d), 64'(32'hFF80_0001 | (32'(SMAX) << 16)));
    wr(3*32 + 'h08, 32'h0005_0000);
    rd(3*32 + 'h08, d); chk("R2 size in range", 64'(d), 64'h0005_0000);
    wr(3*32 + 'h08, 32'h007F_FFFE);
    rd(3*32 + 'h08, d); chk("R2 reserved bits", 64'(d), 64'(32'(SMAX) << 16));
    wr(3*32 + 'h08, 32'h0000_0000);

    // R4: map, base low bits, unused offsets
    wr(6*32 + 'h00, 32'hFFFF_FFFF);
    rd(6*32 + 'h00, d); chk("R4 src low bits", 64'(d), 64'hFFFF_F000);
    wr(6*32 + 'h14, 32'hCAFE_0001);
    rd(6*32 + 'h14, d); chk("R4 dst hi", 64'(d), 64'hCAFE_0001);
    rd(5*32 + 'h14, d); chk("R4 other window", 64'(d), 64'd0);
    wr(6*32 + 'h0C, 32'hFFFF_FFFF);
    rd(6*32 + 'h0C, d); chk("R4 unused 0x0C", 64'(d), 64'd0);
    wr(6*32 + 'h18, 32'hFFFF_FFFF);
    rd(6*32 + 'h18, d); chk("R4 unused 0x18", 64'(d), 64'd0);
    wr(6*32 + 'h00, 32'h0); wr(6*32 + 'h14, 32'h0);

    // R5/R6/R8: size sweep on window 2 at span edges
    for (int s = 0; s <= SMAX; s++) begin
      logic [63:0] src, al, sp;
      src = 64'h1234_5678_9ABC_D000;
      set_win(2, src, 64'hFEDC_BA98_7654_3000, 1'b1, s, 1'b0, 4'h0, 4'h0);
      sp = 64'd1 << (12 + s);
      al = (src >> (12 + s)) << (12 + s);
      do_req(al, 1'b0, 3'b111);
      do_req(al + sp - 64'd1, 1'b1, 3'b111);
      do_req(al + sp, 1'b0, 3'b111);
      do_req(al - 64'd1, 1'b1, 3'b111);
    end
    // R5: disabled window never hits
    set_win(2, 64'h1234_5678_9ABC_D000, 64'h0, 1'b0, 4, 1'b1, 4'h7, 4'h7);
    do_req(64'h1234_5678_9ABC_D000, 1'b0, 3'b111);
    clear_all();

    // R7: nested windows on a common base, size grows with index
    for (int w = 0; w < NW; w++)
      set_win(w, 64'h0000_4000_0000_0000, 64'(w + 1) << 40, 1'b1, w, 1'b1, 4'(w), 4'(7 - w));
    do_req(64'h0000_4000_0000_0000, 1'b0, 3'b111);
    for (int j = 0; j <= NW; j++) begin
      do_req(64'h0000_4000_0000_0000 + (64'd1 << (12 + j)) + 64'h123, 1'b0, 3'b111);
      do_req(64'h0000_4000_0000_0000 + (64'd1 << (12 + j)) + 64'h45, 1'b1, 3'b111);
    end
    clear_all();

    // R9/R10/R11: attribute sweep on window 5
    for (int o = 0; o < 2; o++) begin
      for (int v = 0; v < 8; v++) begin
        set_win(5, 64'h0000_0000_8000_0000, 64'h0000_0010_0000_0000, 1'b1, 0, o[0],
                {v[1], ~v[2:0]}, {v[0], v[2:0]});
        for (int p = 0; p < 8; p++) begin
          do_req(64'h0000_0000_8000_0ABC, 1'b1, 3'(p));
          do_req(64'h0000_0000_8000_0010, 1'b0, 3'(p));
        end
      end
    end

    // R12: back-to-back requests, then idle
    begin
      bit h1, h2; logic [63:0] x1, x2; logic [2:0] t1, t2;
      model(64'h0000_0000_8000_0004, 1'b1, 3'b111, h1, x1, t1);
      model(64'h0000_0000_9000_0000, 1'b0, 3'b111, h2, x2, t2);
      @(negedge clk);
      req_valid = 1'b1; req_is_write = 1'b1; req_addr = 64'h0000_0000_8000_0004; attr_permit = 3'b111;
      @(negedge clk);
      chk("R12 first of burst addr", rsp_addr, x1);
      chk("R12 first of burst hit", 64'(rsp_hit), 64'(h1));
      req_is_write = 1'b0; req_addr = 64'h0000_0000_9000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 second of burst addr", rsp_addr, x2);
      chk("R12 second of burst hit", 64'(rsp_hit), 64'(h2));
      @(negedge clk);
      chk("R12 idle valid", 64'(rsp_valid), 64'd0);
      chk("R12 idle hit", 64'(rsp_hit), 64'd0);
      chk("R12 idle attr", 64'(rsp_attr), 64'd0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule